// File: doc/BRIEF.md
# CAN Bit Timing Resynchronization Unit

This block turns a stream of time-quantum enables into nominal CAN bit times. It divides each bit into four parts, each a whole number of quanta: a one-quantum synchronization slot, a propagation part, and a first and a second phase buffer. It reads the receive line once per quantum. At the sample point, which is the last quantum of the first phase buffer, it raises a one-clock strobe and presents the bus level it read there. It also raises a one-clock bit-start strobe on every quantum that opens a bit, so a transmitter can drive its next bit at that time.

A falling edge on the line shifts the timing. A falling edge is a dominant quantum that follows a recessive level at the last sample point. When the frame logic holds the hard-synchronization flag, such an edge restarts the bit outright. Inside a frame, the same edge instead stretches the first phase buffer or trims the second one. The size of the shift is the edge's distance from the synchronization slot, clamped to the jump width. At most one shift is allowed between two sample points, and each shift lasts for one bit only.

The controller has five states. IDLE waits for the first hard synchronization and leaves on a dominant quantum seen while the flag is set. SYNC is the one-quantum synchronization slot and always leads to PROP. PROP leads to PH1 when its count runs out. PH1 holds the sample point and then leads to PH2. PH2 leads to SYNC when its count runs out. PH2 leads straight to PROP when an early edge is fully compensated, so SYNC is skipped. A hard synchronization from any state leads to PROP.

Top module: `can_bit_resync`

## Requirements
- R1: After reset, `sample_stb` and `bit_start` are 0, `sample_lvl` is 1 (recessive), and the block is idle.
- R2: While idle, nothing happens until a quantum reads the line as 0 (dominant) while `hsync_en` is 1. That quantum becomes the synchronization slot: `bit_start` pulses for it, and the sample strobe follows `prop_len`+`ph1_len` quanta later. Dominant quanta seen while `hsync_en` is 0 produce no strobe.
- R3: With no edges, a bit lasts 1+`prop_len`+`ph1_len`+`ph2_len` quanta. `bit_start` marks the synchronization-slot quantum. `sample_stb` marks the quantum that lies `prop_len`+`ph1_len` after it, and `sample_lvl` then holds `rx_in` as read in that quantum.
- R4: An edge is a quantum where `rx_in` is 0 while the level taken at the last sample point was 1. Dominant quanta that follow a dominant sample do not move the timing.
- R5: An edge that falls in the synchronization slot leaves the sample point in place.
- R6: An edge k quanta after the synchronization slot (within the propagation part or the first phase buffer) delays the sample point by min(k, `sjw_len`) quanta.
- R7: An edge in the second phase buffer, m quanta before the next synchronization slot, moves the next bit start earlier by min(m, `sjw_len`) quanta. When m ≤ `sjw_len`, the edge quantum itself opens the next bit: `bit_start` pulses for it and the slot is skipped.
- R8: Only the first edge between two sample points is acted on. Later edges in that interval are ignored.
- R9: A shift applies to one bit only. The bit after it uses the captured lengths again.
- R10: An edge seen while `hsync_en` is 1 inside a frame restarts the bit at the edge quantum, whatever its phase error.
- R11: Take a dominant spike of `prop_len`+`ph1_len` quanta that starts in the last propagation quantum. If `sjw_len` covers its phase error, a recessive level is sampled; otherwise the dominant level is sampled.
- R12: The four length inputs are captured only while idle. Changes after the first hard synchronization have no effect.
- R13: The timing advances only on cycles where `tq_en` is 1. Both strobes are high only in the clock that follows such a cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tq_en | input | 1 | One-clock enable per time quantum |
| rx_in | input | 1 | Receive line, 1 recessive, 0 dominant |
| hsync_en | input | 1 | Hard synchronization allowed (from frame logic) |
| prop_len | input | SEG_W (5) | Propagation part length, 1 to 16 quanta |
| ph1_len | input | SEG_W (5) | First phase buffer length, 1 to 16 quanta |
| ph2_len | input | SEG_W (5) | Second phase buffer length, 1 to 16 quanta |
| sjw_len | input | SEG_W (5) | Jump width, 1 to 16, not above either phase buffer |
| sample_stb | output | 1 | One-clock sample-point strobe |
| sample_lvl | output | 1 | Bus level read at the last sample point |
| bit_start | output | 1 | One-clock strobe for the quantum opening a bit |

## Verification
The hardest state to reach is a resynchronizing edge at an exact quantum offset from the synchronization slot, because a qualifying edge needs a recessive level at the previous sample point. The stimulus first hard-synchronizes and lets one bit sample dominant and the next sample recessive. It then drops the line at every offset from deep in the second phase buffer to the sample quantum itself, over every legal jump width for a small set of lengths. The expected strobe quanta for that bit and the next one are computed from those offsets. A second recessive-dominant glitch is placed inside the same interval whenever it still precedes the expected sample point.

// File: rtl/bts_pkg.sv
package bts_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SYNC,
        ST_PROP,
        ST_PH1,
        ST_PH2
    } bts_state_e;

endpackage

// File: rtl/bts_clamp.sv
// Limits a phase error magnitude to the jump width.
module bts_clamp #(
    parameter int W     = 6,
    parameter int LIM_W = 5
) (
    input  logic [W-1:0]     mag,
    input  logic [LIM_W-1:0] lim,
    output logic [W-1:0]     amt
);
    localparam int PAD = W - LIM_W;

    logic [W-1:0] lim_w;

    assign lim_w = {{PAD{1'b0}}, lim};
    assign amt   = (mag > lim_w) ? lim_w : mag;

endmodule

// File: rtl/bts_edge.sv
// Falling-edge qualifier with the one-shift-per-sample-interval rule.
module bts_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic tq_en,
    input  logic rx_in,
    input  logic idle,
    input  logic take,
    input  logic sp_hit,
    output logic edge_seen
);
    logic       ref_q;
    logic       synced_q;
    logic [1:0] shift_cnt;

    assign edge_seen = tq_en && ref_q && !rx_in && !synced_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ref_q    <= 1'b1;
            synced_q <= 1'b0;
        end else if (sp_hit) begin
            ref_q    <= rx_in;
            synced_q <= 1'b0;
        end else begin
            if (idle) ref_q <= 1'b1;
            if (take) synced_q <= 1'b1;
        end
    end

    // Shifts taken since the last sample point, kept for the check below.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                          shift_cnt <= 2'd0;
        else if (sp_hit)                     shift_cnt <= 2'd0;
        else if (take && shift_cnt != 2'd3)  shift_cnt <= shift_cnt + 2'd1;
    end

    assert_one_shift_R8: assert property (@(posedge clk) disable iff (!rst_n)
        shift_cnt <= 2'd1);

endmodule

// File: rtl/can_bit_resync.sv
module can_bit_resync #(
    parameter int SEG_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tq_en,
    input  logic             rx_in,
    input  logic             hsync_en,
    input  logic [SEG_W-1:0] prop_len,
    input  logic [SEG_W-1:0] ph1_len,
    input  logic [SEG_W-1:0] ph2_len,
    input  logic [SEG_W-1:0] sjw_len,
    output logic             sample_stb,
    output logic             sample_lvl,
    output logic             bit_start
);
    import bts_pkg::*;

    localparam int LW = SEG_W + 1;
    localparam logic [LW-1:0]    ONE     = LW'(1);
    localparam logic [SEG_W-1:0] SEG_ONE = SEG_W'(1);

    bts_state_e st_q, st_d;

    logic [LW-1:0]    left_q, left_d, pos_q, pos_d, ext_q, ext_d;
    logic [LW-1:0]    ph1_eff, err_mag, adj;
    logic [LW-1:0]    prop_w, ph1_w, ph2_w;
    logic [SEG_W-1:0] prop_q, ph1_q, ph2_q, sjw_q;
    logic [SEG_W-1:0] prop_c, ph1_c, ph2_c, sjw_c;
    logic             idle, edge_seen, take, hard, sp_hit, new_bit;

    // Settings: tracked while idle, frozen afterwards.
    assign idle   = (st_q == ST_IDLE);
    assign prop_c = idle ? prop_len : prop_q;
    assign ph1_c  = idle ? ph1_len  : ph1_q;
    assign ph2_c  = idle ? ph2_len  : ph2_q;
    assign sjw_c  = idle ? sjw_len  : sjw_q;
    assign prop_w = {1'b0, prop_c};
    assign ph1_w  = {1'b0, ph1_c};
    assign ph2_w  = {1'b0, ph2_c};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prop_q <= SEG_ONE;
            ph1_q  <= SEG_ONE;
            ph2_q  <= SEG_ONE;
            sjw_q  <= SEG_ONE;
        end else if (idle) begin
            prop_q <= prop_len;
            ph1_q  <= ph1_len;
            ph2_q  <= ph2_len;
            sjw_q  <= sjw_len;
        end
    end

    bts_edge u_edge (
        .clk       (clk),
        .rst_n     (rst_n),
        .tq_en     (tq_en),
        .rx_in     (rx_in),
        .idle      (idle),
        .take      (take),
        .sp_hit    (sp_hit),
        .edge_seen (edge_seen)
    );

    assign hard = edge_seen && hsync_en;
    assign take = edge_seen && (!idle || hsync_en);

    // Early edges are measured by the quanta left to the slot, late ones by elapsed quanta.
    assign err_mag = (st_q == ST_PH2) ? left_q : pos_q;

    bts_clamp #(.W(LW), .LIM_W(SEG_W)) u_clamp (
        .mag (err_mag),
        .lim (sjw_c),
        .amt (adj)
    );

    assign ph1_eff = left_q + (edge_seen ? adj : '0);

    always_comb begin
        st_d    = st_q;
        left_d  = left_q;
        pos_d   = pos_q;
        ext_d   = ext_q;
        sp_hit  = 1'b0;
        new_bit = 1'b0;
        if (tq_en) begin
            if (hard) begin
                st_d    = ST_PROP;
                left_d  = prop_w;
                pos_d   = ONE;
                ext_d   = '0;
                new_bit = 1'b1;
            end else begin
                unique case (st_q)
                    ST_IDLE: begin
                        st_d = ST_IDLE;
                    end
                    ST_SYNC: begin
                        st_d    = ST_PROP;
                        left_d  = prop_w;
                        pos_d   = ONE;
                        ext_d   = '0;
                        new_bit = 1'b1;
                    end
                    ST_PROP: begin
                        pos_d = pos_q + ONE;
                        if (edge_seen) ext_d = adj;
                        if (left_q > ONE) begin
                            left_d = left_q - ONE;
                        end else begin
                            st_d   = ST_PH1;
                            left_d = ph1_w + (edge_seen ? adj : ext_q);
                        end
                    end
                    ST_PH1: begin
                        pos_d = pos_q + ONE;
                        if (ph1_eff > ONE) begin
                            left_d = ph1_eff - ONE;
                        end else begin
                            sp_hit = 1'b1;
                            st_d   = ST_PH2;
                            left_d = ph2_w;
                            ext_d  = '0;
                        end
                    end
                    ST_PH2: begin
                        if (edge_seen && adj == left_q) begin
                            st_d    = ST_PROP;
                            left_d  = prop_w;
                            pos_d   = ONE;
                            ext_d   = '0;
                            new_bit = 1'b1;
                        end else if (edge_seen) begin
                            left_d = left_q - ONE - adj;
                            if (left_q - ONE - adj == '0) begin
                                st_d   = ST_SYNC;
                                left_d = ONE;
                            end
                        end else if (left_q > ONE) begin
                            left_d = left_q - ONE;
                        end else begin
                            st_d   = ST_SYNC;
                            left_d = ONE;
                        end
                    end
                    default: st_d = ST_IDLE;
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q   <= ST_IDLE;
            left_q <= ONE;
            pos_q  <= ONE;
            ext_q  <= '0;
        end else begin
            st_q   <= st_d;
            left_q <= left_d;
            pos_q  <= pos_d;
            ext_q  <= ext_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sample_stb <= 1'b0;
            sample_lvl <= 1'b1;
            bit_start  <= 1'b0;
        end else begin
            sample_stb <= sp_hit;
            bit_start  <= new_bit;
            if (sp_hit) sample_lvl <= rx_in;
        end
    end

    assert_strobe_after_quantum_R13: assert property (@(posedge clk) disable iff (!rst_n)
        (sample_stb || bit_start) |-> $past(tq_en));

    assert_strobes_exclusive_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !(sample_stb && bit_start));

    assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
        idle |-> (!sample_stb && !bit_start));

    assert_ph1_stretch_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_PH1) |-> (left_q <= ({1'b0, ph1_q} + {1'b0, sjw_q})));

    assert_ph2_trim_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_PH2) |-> (left_q <= {1'b0, ph2_q}));

endmodule

// File: tb/test_can_bit_resync.sv
`timescale 1ns/1ps
module test_can_bit_resync;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tq_en = 1'b0;
    logic       rx_in = 1'b1;
    logic       hsync_en = 1'b0;
    logic [4:0] prop_len = 5'd1, ph1_len = 5'd1, ph2_len = 5'd1, sjw_len = 5'd1;
    logic       sample_stb, sample_lvl, bit_start;

    int tests = 0;
    int fails = 0;

    int    cp, ca, cb, cj, hs_q, nq;
    bit    rx_pat [64];
    bit    hs_pat [64];
    bit    exp_sp [64];
    bit    exp_bs [64];
    bit    exp_lv [64];
    string tg     [64];

    always #2.5 clk = ~clk;

    can_bit_resync i_can_bit_resync (
        .clk        (clk),
        .rst_n      (rst_n),
        .tq_en      (tq_en),
        .rx_in      (rx_in),
        .hsync_en   (hsync_en),
        .prop_len   (prop_len),
        .ph1_len    (ph1_len),
        .ph2_len    (ph2_len),
        .sjw_len    (sjw_len),
        .sample_stb (sample_stb),
        .sample_lvl (sample_lvl),
        .bit_start  (bit_start)
    );

    task automatic check(input bit ok, input string msg);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s", msg);
        end
    endtask

    task automatic step(input logic lvl, input logic hs,
                        output logic s, output logic b, output logic l);
        @(negedge clk);
        rx_in = lvl; hsync_en = hs; tq_en = 1'b1;
        @(negedge clk);
        tq_en = 1'b0;
        s = sample_stb; b = bit_start; l = sample_lvl;
        @(negedge clk);
        check(!sample_stb && !bit_start,
              $sformatf("R13 strobe without quantum act=%b%b exp=00", sample_stb, bit_start));
    endtask

    task automatic clear_script();
        for (int q = 0; q < 64; q++) begin
            rx_pat[q] = 1'b1; hs_pat[q] = 1'b0;
            exp_sp[q] = 1'b0; exp_bs[q] = 1'b0; exp_lv[q] = 1'b0;
            tg[q] = "R3";
        end
    endtask

    task automatic run_script();
        logic s, b, l;
        rst_n = 1'b0; tq_en = 1'b0; rx_in = 1'b1; hsync_en = 1'b0;
        prop_len = 5'(cp); ph1_len = 5'(ca); ph2_len = 5'(cb); sjw_len = 5'(cj);
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(!sample_stb && !bit_start && sample_lvl,
              $sformatf("R1 reset act=%b%b%b exp=001", sample_stb, bit_start, sample_lvl));
        for (int q = 0; q < nq; q++) begin
            step(rx_pat[q], hs_pat[q], s, b, l);
            if (q == hs_q) begin
                // R12: settings changed after leaving idle
                prop_len = 5'd13; ph1_len = 5'd16; ph2_len = 5'd9; sjw_len = 5'd7;
            end
            check(s == exp_sp[q] && b == exp_bs[q],
                  $sformatf("%s q=%0d cfg=%0d/%0d/%0d/%0d stb,bs act=%b%b exp=%b%b",
                            tg[q], q, cp, ca, cb, cj, s, b, exp_sp[q], exp_bs[q]));
            if (exp_sp[q] && s)
                check(l == exp_lv[q],
                      $sformatf("%s q=%0d sample_lvl act=%b exp=%b", tg[q], q, l, exp_lv[q]));
        end
    endtask

    // Hard sync at quantum 0, dominant then recessive sample, then one edge at offset d.
    task automatic fill_main(input int p, input int a, input int b, input int j, input int d);
        int n, sp0, sp1, qe, s, sp2, bs2, sp3, bs3;
        bit glitch;
        string dt;
        clear_script();
        cp = p; ca = a; cb = b; cj = j; hs_q = 0;
        n = 1 + p + a + b; sp0 = p + a; sp1 = n + p + a;
        if (d >= 0) begin
            qe = 2*n + d; s = (d < j) ? d : j;
            sp2 = 2*n + p + a + s; bs2 = 2*n;
            dt = (d == 0) ? "R5" : "R6";
        end else begin
            qe = 2*n + d; s = (-d < j) ? -d : j;
            sp2 = 2*n - s + p + a; bs2 = 2*n - s;
            dt = "R7";
        end
        sp3 = sp2 + n; bs3 = sp2 + b + 1; nq = sp3 + 2;
        glitch = (qe + 2 < sp2);
        if (glitch) dt = {dt, "/R8"};
        for (int q = 0; q < nq; q++) begin
            if (q <= sp0)          rx_pat[q] = 1'b0;
            else if (q < qe)       rx_pat[q] = 1'b1;
            else if (q == qe + 1)  rx_pat[q] = glitch;
            else                   rx_pat[q] = 1'b0;
            if (q <= sp1)      tg[q] = "R3/R12";
            else if (q <= sp2) tg[q] = dt;
            else               tg[q] = "R4/R9";
        end
        hs_pat[0] = 1'b1;
        exp_sp[sp0] = 1'b1; exp_lv[sp0] = 1'b0;
        exp_sp[sp1] = 1'b1; exp_lv[sp1] = 1'b1;
        exp_sp[sp2] = 1'b1; exp_lv[sp2] = 1'b0;
        exp_sp[sp3] = 1'b1; exp_lv[sp3] = 1'b0;
        exp_bs[0] = 1'b1; exp_bs[n] = 1'b1; exp_bs[bs2] = 1'b1; exp_bs[bs3] = 1'b1;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired act=running exp=done");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        // R2: idle ignores dominant quanta until hard sync is allowed (1/2/2, jump 1).
        clear_script();
        cp = 1; ca = 2; cb = 2; cj = 1; hs_q = 10; nq = 21;
        for (int q = 0; q < nq; q++) begin
            rx_pat[q] = 1'b0;
            tg[q] = (q <= 13) ? "R2" : "R4";
        end
        hs_pat[10] = 1'b1;
        exp_bs[10] = 1'b1; exp_sp[13] = 1'b1; exp_bs[16] = 1'b1; exp_sp[19] = 1'b1;
        run_script();

        // R10: hard sync inside a frame overrides the jump width (2/3/3, jump 1).
        clear_script();
        cp = 2; ca = 3; cb = 3; cj = 1; hs_q = 0; nq = 31;
        for (int q = 0; q < nq; q++) begin
            rx_pat[q] = (q <= 5 || q >= 15) ? 1'b0 : 1'b1;
            tg[q] = (q < 15) ? "R3" : "R10";
        end
        hs_pat[0] = 1'b1; hs_pat[15] = 1'b1;
        exp_bs[0] = 1'b1; exp_sp[5] = 1'b1; exp_bs[9] = 1'b1; exp_sp[14] = 1'b1; exp_lv[14] = 1'b1;
        exp_bs[15] = 1'b1; exp_sp[20] = 1'b1; exp_bs[24] = 1'b1; exp_sp[29] = 1'b1;
        run_script();

        // R11: spike of prop+ph1 quanta from the last propagation quantum.
        for (int j = 1; j <= 3; j++) begin
            int sp2;
            clear_script();
            cp = 2; ca = 3; cb = 3; cj = j; hs_q = 0;
            sp2 = 23 + ((j < 2) ? j : 2);
            nq = sp2 + 11;
            for (int q = 0; q < nq; q++) begin
                rx_pat[q] = (q <= 5 || (q >= 20 && q <= 24)) ? 1'b0 : 1'b1;
                tg[q] = (q <= 14) ? "R3" : "R11";
            end
            hs_pat[0] = 1'b1;
            exp_bs[0] = 1'b1; exp_sp[5] = 1'b1; exp_bs[9] = 1'b1; exp_sp[14] = 1'b1; exp_lv[14] = 1'b1;
            exp_bs[18] = 1'b1; exp_sp[sp2] = 1'b1; exp_lv[sp2] = (j >= 2);
            exp_bs[sp2 + 4] = 1'b1; exp_sp[sp2 + 9] = 1'b1; exp_lv[sp2 + 9] = 1'b1;
            run_script();
        end

        // R5, R6, R7, R8, R9, R12: every edge offset over small settings.
        for (int p = 1; p <= 2; p++)
            for (int a = 1; a <= 3; a++)
                for (int b = 1; b <= 3; b++)
                    for (int j = 1; j <= ((a < b) ? a : b); j++)
                        for (int d = -b; d <= p + a; d++) begin
                            fill_main(p, a, b, j, d);
                            run_script();
                        end

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule